// File: doc/BRIEF.md
# Shared-Pin Multiplexer with Reset-Safe Output Gating

This block decides, pin by pin, whether a set of package pins is driven by an external-memory controller or by a timer module that shares those pins. For each pin it produces output data, an output enable and a pull-down control. Two gates protect the pins after reset. One covers the memory clock. The other covers the group of memory address, bank and chip-select outputs. Both gates come up closed, so no memory signal drives a line until software has configured the block.

Each gate is a pair of control bits, a block bit and an enable bit. A gate opens only for the single combination block=0, enable=1. Every other combination, including a half-finished configuration, keeps the gate closed. A pin that is set to the memory function while its gate is closed becomes a pulled-down input. A pin set to the timer function carries the timer's data and enable whatever the gate bits hold. The block also stores one mode bit that chooses between the reduced and the full media-independent Ethernet interface.

Software sets these bits through a write-only port. A write takes effect on the next clock edge.

Top module: `pmx_top`

## Requirements
- R1: After reset the memory clock output enable is 0 and the clock pin is 0. The Ethernet mode output is 1. Every pin is set to the timer function (pad_out = tmr_out, pad_oe = tmr_oe, pad_pd = 0).
- R2: The memory clock gate uses bit 0 (block, reset value 1) and bit 1 (enable, reset value 0) of the gate register at address 0. mem_clk_oe is 1 and mem_clk_pad follows mem_clk_in only when block=0 and enable=1. For every other combination both outputs are 0.
- R3: The shared-pin group gate uses bit 2 (block, reset value 1) and bit 3 (enable, reset value 0) of register 0. If a pin is set to the memory function and this gate is in any state other than block=0, enable=1, that pin gives pad_oe=0, pad_out=0 and pad_pd=1.
- R4: If a pin is set to the memory function and the group gate is open, that pin gives pad_out = mem_out, pad_oe = mem_oe and pad_pd = 0.
- R5: The function-select register is at address 1, one bit per pin, with bit i controlling pin i. A value of 0 selects the timer and 1 selects memory. A timer pin gives pad_out = tmr_out, pad_oe = tmr_oe and pad_pd = 0, whatever the gate bits hold.
- R6: The Ethernet mode bit is bit 4 of register 0 and resets to 1 (reduced interface). Writing 0 gives eth_reduced = 0 (full interface). Writing 1 restores it.
- R7: A write changes the outputs from the first clock edge on which wr_en is sampled high. A write to address 2 or 3 has no effect on any output. Input values present while wr_en is low have no effect.
- R8: A synchronous active-high reset returns every control bit to its reset value, even after earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 gate, 1 function select) |
| wr_data | input | DATA_W | Write data |
| mem_clk_in | input | 1 | Clock from the memory controller |
| mem_out | input | NPIN | Memory controller data per shared pin |
| mem_oe | input | NPIN | Memory controller output enable per pin |
| tmr_out | input | NPIN | Timer data per shared pin |
| tmr_oe | input | NPIN | Timer output enable per pin |
| mem_clk_pad | output | 1 | Gated memory clock toward its pin |
| mem_clk_oe | output | 1 | Output enable of the memory clock pin |
| eth_reduced | output | 1 | 1 selects the reduced Ethernet interface, 0 the full one |
| pad_out | output | NPIN | Data toward each shared pin |
| pad_oe | output | NPIN | Output enable of each shared pin |
| pad_pd | output | NPIN | Pull-down enable of each shared pin |

## Verification
The assertions treat the gate register as the only thing that moves the memory clock and Ethernet outputs. They also assume the timer's enable inputs are meaningful in every cycle, because a pin set to the timer function passes them straight through. The stimulus holds wr_en low except during deliberate one-cycle writes. It changes the data inputs only when no write is in flight. It drives rst high from time zero, so every property starts after a clean reset.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    localparam int ADDR_GATE = 0;
    localparam int ADDR_FSEL = 1;

    localparam int B_MCLK_BLK = 0;
    localparam int B_MCLK_EN  = 1;
    localparam int B_GRP_BLK  = 2;
    localparam int B_GRP_EN   = 3;
    localparam int B_ETH_RED  = 4;
    localparam int CTRL_W     = 5;

    typedef struct packed {
        logic eth_red;
        logic grp_en;
        logic grp_blk;
        logic mclk_en;
        logic mclk_blk;
    } gate_ctrl_t;

    localparam gate_ctrl_t CTRL_RESET = '{
        eth_red:  1'b1,
        grp_en:   1'b0,
        grp_blk:  1'b1,
        mclk_en:  1'b0,
        mclk_blk: 1'b1
    };

    typedef enum logic {
        FN_TIMER = 1'b0,
        FN_MEM   = 1'b1
    } pin_fn_e;

    typedef struct packed {
        logic dat;
        logic oe;
        logic pd;
    } pad_drive_t;

    // Only one of the four pair states opens a gate.
    function automatic logic pair_open(input logic blk, input logic en);
        return (!blk) && en;
    endfunction

endpackage

// File: rtl/pmx_ctrl_regs.sv
module pmx_ctrl_regs
    import pmx_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output gate_ctrl_t        ctrl,
    output logic [NPIN-1:0]   fsel
);

    logic hit_gate;
    logic hit_fsel;

    assign hit_gate = wr_en && (wr_addr == ADDR_W'(ADDR_GATE));
    assign hit_fsel = wr_en && (wr_addr == ADDR_W'(ADDR_FSEL));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else if (hit_gate) begin
            ctrl.mclk_blk <= wr_data[B_MCLK_BLK];
            ctrl.mclk_en  <= wr_data[B_MCLK_EN];
            ctrl.grp_blk  <= wr_data[B_GRP_BLK];
            ctrl.grp_en   <= wr_data[B_GRP_EN];
            ctrl.eth_red  <= wr_data[B_ETH_RED];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel <= '0;
        end else if (hit_fsel) begin
            fsel <= wr_data[NPIN-1:0];
        end
    end

endmodule

// File: rtl/pmx_gate.sv
module pmx_gate
    import pmx_pkg::*;
(
    input  logic blk,
    input  logic en,
    output logic open
);

    assign open = pair_open(blk, en);

endmodule

// File: rtl/pmx_pin_cell.sv
module pmx_pin_cell
    import pmx_pkg::*;
(
    input  pin_fn_e    fn,
    input  logic       grp_open,
    input  logic       mem_dat,
    input  logic       mem_en,
    input  logic       tmr_dat,
    input  logic       tmr_en,
    output pad_drive_t drv
);

    always_comb begin
        unique case (fn)
            FN_TIMER: drv = '{dat: tmr_dat, oe: tmr_en, pd: 1'b0};
            FN_MEM: begin
                if (grp_open) drv = '{dat: mem_dat, oe: mem_en, pd: 1'b0};
                else          drv = '{dat: 1'b0, oe: 1'b0, pd: 1'b1};
            end
            default:  drv = '{dat: 1'b0, oe: 1'b0, pd: 1'b1};
        endcase
    end

endmodule

// File: rtl/pmx_top.sv
module pmx_top
    import pmx_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mem_clk_in,
    input  logic [NPIN-1:0]   mem_out,
    input  logic [NPIN-1:0]   mem_oe,
    input  logic [NPIN-1:0]   tmr_out,
    input  logic [NPIN-1:0]   tmr_oe,
    output logic              mem_clk_pad,
    output logic              mem_clk_oe,
    output logic              eth_reduced,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_pd
);

    gate_ctrl_t      ctrl;
    logic [NPIN-1:0] fsel;
    logic            mclk_open;
    logic            grp_open;

    pmx_ctrl_regs #(
        .NPIN   (NPIN),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .fsel    (fsel)
    );

    pmx_gate u_mclk_gate (
        .blk  (ctrl.mclk_blk),
        .en   (ctrl.mclk_en),
        .open (mclk_open)
    );

    pmx_gate u_grp_gate (
        .blk  (ctrl.grp_blk),
        .en   (ctrl.grp_en),
        .open (grp_open)
    );

    assign mem_clk_oe  = mclk_open;
    assign mem_clk_pad = mem_clk_in & mclk_open;
    assign eth_reduced = ctrl.eth_red;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pad_drive_t drv;
        pmx_pin_cell u_cell (
            .fn       (pin_fn_e'(fsel[i])),
            .grp_open (grp_open),
            .mem_dat  (mem_out[i]),
            .mem_en   (mem_oe[i]),
            .tmr_dat  (tmr_out[i]),
            .tmr_en   (tmr_oe[i]),
            .drv      (drv)
        );
        assign pad_out[i] = drv.dat;
        assign pad_oe[i]  = drv.oe;
        assign pad_pd[i]  = drv.pd;
    end

endmodule

// File: rtl/pmx_checker.sv
module pmx_checker #(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [4:0]        wr_ctl,
    input logic              mem_clk_pad,
    input logic              mem_clk_oe,
    input logic              eth_reduced,
    input logic [NPIN-1:0]   tmr_oe,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe,
    input logic [NPIN-1:0]   pad_pd
);

    logic gate_wr;
    assign gate_wr = wr_en && (wr_addr == '0);

    AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mem_clk_oe && eth_reduced && pad_pd == '0)); // R1

    AST_CLK_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !mem_clk_oe |-> !mem_clk_pad); // R2

    AST_CLK_BLOCK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (gate_wr && (wr_ctl[0] || !wr_ctl[1])) |=> !mem_clk_oe); // R2

    AST_PD_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (pad_pd & pad_oe) == '0); // R3

    AST_PD_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (pad_pd & pad_out) == '0); // R3

    AST_GRP_BLOCK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (gate_wr && (wr_ctl[2] || !wr_ctl[3])) |=> ((pad_oe & ~tmr_oe) == '0)); // R5

    AST_ETH_WRITE: assert property (@(posedge clk) disable iff (rst)
        gate_wr |=> (eth_reduced == $past(wr_ctl[4]))); // R6

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !gate_wr |=> ($stable(mem_clk_oe) && $stable(eth_reduced))); // R7

endmodule

bind pmx_top pmx_checker #(
    .NPIN   (NPIN),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_ctl      (wr_data[4:0]),
    .mem_clk_pad (mem_clk_pad),
    .mem_clk_oe  (mem_clk_oe),
    .eth_reduced (eth_reduced),
    .tmr_oe      (tmr_oe),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pd      (pad_pd)
);

// File: tb/tb_pmx_top.sv
`timescale 1ns/1ps
module tb_pmx_top;

    localparam int NPIN   = 8;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              mem_clk_in = 1'b0;
    logic [NPIN-1:0]   mem_out = '0, mem_oe = '0, tmr_out = '0, tmr_oe = '0;
    logic              mem_clk_pad, mem_clk_oe, eth_reduced;
    logic [NPIN-1:0]   pad_out, pad_oe, pad_pd;

    always #2 clk = ~clk;

    pmx_top #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mem_clk_in(mem_clk_in), .mem_out(mem_out), .mem_oe(mem_oe),
        .tmr_out(tmr_out), .tmr_oe(tmr_oe),
        .mem_clk_pad(mem_clk_pad), .mem_clk_oe(mem_clk_oe), .eth_reduced(eth_reduced),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd(pad_pd)
    );

    typedef struct {
        string           tag;
        logic [NPIN-1:0] dat, oe, pd;
        logic            cpad, coe, eth;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // Shadow of the control bits, kept from the requirement encodings.
    logic [4:0]      sh_gate = 5'b10101;
    logic [NPIN-1:0] sh_sel  = '0;

    task automatic do_reset();
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        sh_gate = 5'b10101;
        sh_sel  = '0;
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        @(posedge clk); #1 wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(posedge clk); #1 wr_en = 1'b0;
        if (a == 0) sh_gate = d[4:0];
        else if (a == 1) sh_sel = d[NPIN-1:0];
    endtask

    task automatic drive(input logic c, input logic [NPIN-1:0] mo, moe, to, toe);
        mem_clk_in = c; mem_out = mo; mem_oe = moe; tmr_out = to; tmr_oe = toe;
    endtask

    // Driver: compute expected outputs from the requirements and queue them.
    task automatic expect_now(input string tag);
        exp_t e;
        logic mopen, gopen;
        mopen = !sh_gate[0] && sh_gate[1];
        gopen = !sh_gate[2] && sh_gate[3];
        e.tag  = tag;
        e.coe  = mopen;
        e.cpad = mopen & mem_clk_in;
        e.eth  = sh_gate[4];
        for (int i = 0; i < NPIN; i++) begin
            if (!sh_sel[i]) begin
                e.dat[i] = tmr_out[i]; e.oe[i] = tmr_oe[i]; e.pd[i] = 1'b0;
            end else if (gopen) begin
                e.dat[i] = mem_out[i]; e.oe[i] = mem_oe[i]; e.pd[i] = 1'b0;
            end else begin
                e.dat[i] = 1'b0; e.oe[i] = 1'b0; e.pd[i] = 1'b1;
            end
        end
        q.push_back(e);
        @(negedge clk);
        #0.5;
    endtask

    // Monitor: pop one item per falling edge and compare.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (pad_out !== e.dat || pad_oe !== e.oe || pad_pd !== e.pd ||
                mem_clk_pad !== e.cpad || mem_clk_oe !== e.coe || eth_reduced !== e.eth) begin
                n_fail++;
                $display("FAIL %s: got out=%h oe=%h pd=%h cpad=%b coe=%b eth=%b exp out=%h oe=%h pd=%h cpad=%b coe=%b eth=%b",
                         e.tag, pad_out, pad_oe, pad_pd, mem_clk_pad, mem_clk_oe, eth_reduced,
                         e.dat, e.oe, e.pd, e.cpad, e.coe, e.eth);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        drive(1'b1, 8'h3C, 8'hF0, 8'hA5, 8'h0F);
        do_reset();
        expect_now("R1 reset defaults");

        wr(1, 8'hFF);
        expect_now("R3 memory select, group blocked by reset");

        wr(0, 8'h10);
        expect_now("R2 R3 block=0 enable=0 stays closed");

        wr(0, 8'h1F);
        expect_now("R2 R3 block=1 enable=1 stays closed");

        wr(0, 8'h1A);
        expect_now("R2 R4 both gates open");
        drive(1'b0, 8'hC3, 8'h5A, 8'h00, 8'hFF);
        expect_now("R2 R4 clock low and new memory pattern");

        wr(1, 8'h0F);
        drive(1'b1, 8'h96, 8'hFF, 8'h69, 8'hAA);
        expect_now("R4 R5 mixed select, group open");

        wr(0, 8'h15);
        expect_now("R3 R5 gates closed again, timer pins unaffected");

        wr(0, 8'h0A);
        expect_now("R6 full Ethernet interface selected");
        wr(0, 8'h1A);
        expect_now("R6 reduced interface restored");

        wr(2, 8'h00);
        expect_now("R7 write to unused address 2");
        wr(3, 8'h05);
        expect_now("R7 write to unused address 3");

        @(posedge clk); #1 wr_addr = 2'd0; wr_data = 8'h05;
        expect_now("R7 data present with wr_en low");

        @(posedge clk); #1 wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h06;
        @(posedge clk); #0.5;
        sh_gate = 5'b00110;
        wr_en = 1'b0;
        #0.5;
        expect_now("R7 R2 write visible after the sampling edge, clock only");

        wr(1, 8'hF0);
        drive(1'b1, 8'hFF, 8'hFF, 8'h11, 8'h22);
        expect_now("R3 R5 high pins memory blocked, low pins timer");

        do_reset();
        expect_now("R8 reset after writes restores defaults");
        wr(1, 8'hFF);
        expect_now("R8 group gate back to blocked");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule